// File: doc/BRIEF.md
# Threshold Interrupt Controller with Persistence Filtering

This block watches a stream of 16-bit conversion results from two independent sources, an ambient-light channel and a proximity channel, and decides when to raise a level interrupt. Each source has its own low and high threshold, its own enable, its own 4-bit persistence code and its own clear strobe. A result is out of range when it lies strictly outside the window set by the two thresholds. A source fires once enough out-of-range results have arrived in a row.

When a source fires while its enable is set, a sticky pending flag is set. The flag stays set until that source's clear strobe arrives. The active-low interrupt output is pulled low while either enabled source is pending. The two pending flags are also reported in a status byte at fixed bit positions. The two sources decode the persistence code differently: proximity counts linearly, while ambient light uses a coarser scale that reaches 60 results.

Top module: `thr_irq`

## Requirements
- R1: A result counts as out of range only when it is strictly below the low threshold or strictly above the high threshold. A result equal to either threshold is in range.
- R2: Light persistence codes 0 to 15 require, in order, 0 (every result), 1, 2, 3, 5, 10, 15, 20, 25, 30, 35, 40, 45, 50, 55 and 60 consecutive out-of-range results. From code 4 upward the count is (code-3)*5.
- R3: Proximity persistence code N (1 to 15) requires exactly N consecutive out-of-range results.
- R4: Persistence code 0 fires on every valid result, whatever the thresholds.
- R5: A valid in-range result restarts that source's run of consecutive out-of-range results at zero. Cycles without a valid strobe leave the run unchanged.
- R6: A pending flag stays set until its own clear strobe arrives. Clearing one source leaves the other source's flag unchanged.
- R7: If a clear strobe arrives in the same cycle as a result that fires, the flag stays set.
- R8: A source that fires while its enable is low does not set its pending flag.
- R9: `status` bit 4 carries the light pending flag and bit 5 carries the proximity pending flag. All other status bits read 0.
- R10: `irq_n` is 0 while (light pending and light enable) or (proximity pending and proximity enable) holds, and 1 otherwise.
- R11: Flags and status change on the rising clock edge that samples the valid or clear strobe.
- R12: After reset both flags are 0, `irq_n` is 1 and both runs are at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lt_valid | input | 1 | Light result strobe |
| lt_data | input | 16 | Light channel 0 result |
| lt_lo | input | 16 | Light low threshold |
| lt_hi | input | 16 | Light high threshold |
| lt_en | input | 1 | Light interrupt enable |
| lt_pers | input | 4 | Light persistence code |
| lt_clr | input | 1 | Light pending clear strobe |
| px_valid | input | 1 | Proximity result strobe |
| px_data | input | 16 | Proximity result |
| px_lo | input | 16 | Proximity low threshold |
| px_hi | input | 16 | Proximity high threshold |
| px_en | input | 1 | Proximity interrupt enable |
| px_pers | input | 4 | Proximity persistence code |
| px_clr | input | 1 | Proximity pending clear strobe |
| lt_pend | output | 1 | Light pending flag |
| px_pend | output | 1 | Proximity pending flag |
| status | output | 8 | Status byte holding the pending flags |
| irq_n | output | 1 | Combined interrupt, active low |

## Verification
The checker tests the following on every cycle:
- A flag holds until its clear arrives (R6).
- A flag rises only after an enabled, valid result.
- A clear with no coinciding result drops the flag.
- Code 0 fires on any valid result.
- An in-range result from an idle state sets nothing.

Other behaviours depend on long histories and only the bench scenarios show them:
- The exact run lengths for the light scale and the linear proximity scale, including the 60-result top code.
- The restart of a run after an in-range result.
- The equality boundaries.
- The masking by enable.

// File: rtl/thr_irq_pkg.sv
package thr_irq_pkg;

    localparam int DEF_DATA_W = 16;
    localparam int PERS_W     = 4;
    localparam int CNT_W      = 6;
    localparam int N_SRC      = 2;

    typedef enum logic {
        SRC_LIGHT = 1'b0,
        SRC_PROX  = 1'b1
    } src_kind_e;

    typedef struct packed {
        logic oor;
        logic fire;
    } eval_t;

    // Decode a persistence code into the number of consecutive
    // out-of-range results needed before the source fires.
    function automatic logic [CNT_W-1:0] persist_target(src_kind_e kind,
                                                        logic [PERS_W-1:0] code);
        logic [CNT_W-1:0] wide;
        wide = CNT_W'(code);
        if (kind == SRC_LIGHT && code > PERS_W'(3))
            return CNT_W'((wide - CNT_W'(3)) * CNT_W'(5));
        return wide;
    endfunction

    function automatic src_kind_e kind_of(int idx);
        return (idx == 0) ? SRC_LIGHT : SRC_PROX;
    endfunction

endpackage

// File: rtl/thr_range_check.sv
module thr_range_check #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    output logic              oor
);
    logic below;
    logic above;

    always_comb begin
        below = data < lo;
        above = data > hi;
        oor   = below | above;
    end
endmodule

// File: rtl/thr_persist_filter.sv
module thr_persist_filter
    import thr_irq_pkg::*;
#(
    parameter src_kind_e KIND = SRC_LIGHT,
    parameter int        PW   = PERS_W,
    parameter int        CW   = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  logic          oor,
    input  logic [PW-1:0] code,
    output eval_t         ev
);
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] run_q;
    logic [CW-1:0] run_inc;
    logic [CW-1:0] target;
    logic          every;

    always_comb begin
        target  = CW'(persist_target(KIND, code));
        every   = (code == '0);
        run_inc = (run_q == CNT_MAX) ? run_q : run_q + CW'(1);
        ev.oor  = oor;
        ev.fire = valid & (every | (oor & (run_inc >= target)));
    end

    always_ff @(posedge clk) begin
        if (rst)
            run_q <= '0;
        else if (valid)
            run_q <= oor ? run_inc : '0;
    end
endmodule

// File: rtl/thr_pending_flag.sv
module thr_pending_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else
            pend <= set | (pend & ~clr);
    end
endmodule

// File: rtl/thr_irq.sv
module thr_irq
    import thr_irq_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int PW     = PERS_W,
    parameter int CW     = CNT_W,
    parameter int LT_BIT = 4,
    parameter int PX_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lt_valid,
    input  logic [DATA_W-1:0] lt_data,
    input  logic [DATA_W-1:0] lt_lo,
    input  logic [DATA_W-1:0] lt_hi,
    input  logic              lt_en,
    input  logic [PW-1:0]     lt_pers,
    input  logic              lt_clr,
    input  logic              px_valid,
    input  logic [DATA_W-1:0] px_data,
    input  logic [DATA_W-1:0] px_lo,
    input  logic [DATA_W-1:0] px_hi,
    input  logic              px_en,
    input  logic [PW-1:0]     px_pers,
    input  logic              px_clr,
    output logic              lt_pend,
    output logic              px_pend,
    output logic [7:0]        status,
    output logic              irq_n
);
    logic [N_SRC-1:0]             s_valid;
    logic [N_SRC-1:0][DATA_W-1:0] s_data;
    logic [N_SRC-1:0][DATA_W-1:0] s_lo;
    logic [N_SRC-1:0][DATA_W-1:0] s_hi;
    logic [N_SRC-1:0]             s_en;
    logic [N_SRC-1:0][PW-1:0]     s_pers;
    logic [N_SRC-1:0]             s_clr;
    logic [N_SRC-1:0]             s_pend;

    always_comb begin
        s_valid = {px_valid, lt_valid};
        s_data  = {px_data, lt_data};
        s_lo    = {px_lo, lt_lo};
        s_hi    = {px_hi, lt_hi};
        s_en    = {px_en, lt_en};
        s_pers  = {px_pers, lt_pers};
        s_clr   = {px_clr, lt_clr};
    end

    for (genvar gi = 0; gi < N_SRC; gi++) begin : g_src
        logic  oor;
        eval_t ev;

        thr_range_check #(.DATA_W(DATA_W)) u_rng (
            .data (s_data[gi]),
            .lo   (s_lo[gi]),
            .hi   (s_hi[gi]),
            .oor  (oor)
        );

        thr_persist_filter #(.KIND(kind_of(gi)), .PW(PW), .CW(CW)) u_flt (
            .clk   (clk),
            .rst   (rst),
            .valid (s_valid[gi]),
            .oor   (oor),
            .code  (s_pers[gi]),
            .ev    (ev)
        );

        thr_pending_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .set  (ev.fire & s_en[gi]),
            .clr  (s_clr[gi]),
            .pend (s_pend[gi])
        );
    end

    always_comb begin
        lt_pend        = s_pend[0];
        px_pend        = s_pend[1];
        status         = '0;
        status[LT_BIT] = s_pend[0];
        status[PX_BIT] = s_pend[1];
        irq_n          = ~|(s_pend & s_en);
    end
endmodule

// File: rtl/thr_irq_chk.sv
module thr_irq_chk #(
    parameter int DATA_W = 16,
    parameter int PW     = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              lt_valid,
    input logic [DATA_W-1:0] lt_data,
    input logic [DATA_W-1:0] lt_lo,
    input logic [DATA_W-1:0] lt_hi,
    input logic              lt_en,
    input logic [PW-1:0]     lt_pers,
    input logic              lt_clr,
    input logic              px_valid,
    input logic              px_en,
    input logic [PW-1:0]     px_pers,
    input logic              px_clr,
    input logic              lt_pend,
    input logic              px_pend
);
    // R6
    lt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (lt_pend && !lt_clr) |=> lt_pend);
    // R6
    px_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (px_pend && !px_clr) |=> px_pend);
    // R8
    lt_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!lt_pend && !(lt_valid && lt_en)) |=> !lt_pend);
    // R8
    px_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!px_pend && !(px_valid && px_en)) |=> !px_pend);
    // R7
    lt_clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (lt_clr && !lt_valid) |=> !lt_pend);
    // R4
    lt_zero_persist_chk: assert property (@(posedge clk) disable iff (rst)
        (lt_valid && lt_en && lt_pers == '0) |=> lt_pend);
    // R4
    px_zero_persist_chk: assert property (@(posedge clk) disable iff (rst)
        (px_valid && px_en && px_pers == '0) |=> px_pend);
    // R1
    lt_inrange_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!lt_pend && lt_valid && lt_pers != '0 && lt_data >= lt_lo && lt_data <= lt_hi)
        |=> !lt_pend);
endmodule

bind thr_irq thr_irq_chk #(.DATA_W(DATA_W), .PW(PW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lt_valid (lt_valid),
    .lt_data  (lt_data),
    .lt_lo    (lt_lo),
    .lt_hi    (lt_hi),
    .lt_en    (lt_en),
    .lt_pers  (lt_pers),
    .lt_clr   (lt_clr),
    .px_valid (px_valid),
    .px_en    (px_en),
    .px_pers  (px_pers),
    .px_clr   (px_clr),
    .lt_pend  (lt_pend),
    .px_pend  (px_pend)
);

// File: tb/tb_thr_irq.sv
module tb_thr_irq;
    logic        clk = 0;
    logic        rst = 1;
    logic        lt_valid = 0, lt_en = 0, lt_clr = 0;
    logic [15:0] lt_data = 0, lt_lo = 0, lt_hi = 16'hFFFF;
    logic [3:0]  lt_pers = 0;
    logic        px_valid = 0, px_en = 0, px_clr = 0;
    logic [15:0] px_data = 0, px_lo = 0, px_hi = 16'hFFFF;
    logic [3:0]  px_pers = 0;
    logic        lt_pend, px_pend, irq_n;
    logic [7:0]  status;

    thr_irq dut (.*);

    always #2 clk = ~clk;

    typedef struct {
        logic       lp;
        logic       pp;
        logic       irqn;
        logic [7:0] st;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    int   m_lcnt = 0, m_pcnt = 0;
    logic m_lp = 0, m_pp = 0;

    function automatic int lt_need(logic [3:0] c);
        if (c <= 3) return int'(c);
        return (int'(c) - 3) * 5;
    endfunction

    // One clock: apply the current stimulus, advance the model, queue the expectation.
    task automatic step(string tag);
        bit l_oor, p_oor, l_fire, p_fire;
        exp_t e;
        l_oor  = (lt_data < lt_lo) || (lt_data > lt_hi);
        p_oor  = (px_data < px_lo) || (px_data > px_hi);
        l_fire = lt_valid && (lt_pers == 0 || (l_oor && (m_lcnt + 1) >= lt_need(lt_pers)));
        p_fire = px_valid && (px_pers == 0 || (p_oor && (m_pcnt + 1) >= int'(px_pers)));
        if (lt_valid) m_lcnt = l_oor ? ((m_lcnt < 63) ? m_lcnt + 1 : 63) : 0;
        if (px_valid) m_pcnt = p_oor ? ((m_pcnt < 63) ? m_pcnt + 1 : 63) : 0;
        m_lp = (m_lp && !lt_clr) || (l_fire && lt_en);
        m_pp = (m_pp && !px_clr) || (p_fire && px_en);
        e.lp   = m_lp;
        e.pp   = m_pp;
        e.irqn = !((m_lp && lt_en) || (m_pp && px_en));
        e.st   = {2'b00, m_pp, m_lp, 4'b0000};
        e.tag  = tag;
        q.push_back(e);
        @(negedge clk);
        lt_valid = 0; lt_clr = 0; px_valid = 0; px_clr = 0;
    endtask

    task automatic lt_res(logic [15:0] d, string tag);
        lt_valid = 1; lt_data = d; step(tag);
    endtask

    task automatic px_res(logic [15:0] d, string tag);
        px_valid = 1; px_data = d; step(tag);
    endtask

    // Monitor: compare each queued item one step after the sampling edge.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (lt_pend !== e.lp || px_pend !== e.pp || irq_n !== e.irqn || status !== e.st) begin
                    n_fail++;
                    $display("FAIL %s: got lp=%b pp=%b irq_n=%b st=%h, exp lp=%b pp=%b irq_n=%b st=%h",
                             e.tag, lt_pend, px_pend, irq_n, status, e.lp, e.pp, e.irqn, e.st);
                end
            end
        end
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: got timeout, exp completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R12 reset state
        n_chk++;
        if (lt_pend !== 0 || px_pend !== 0 || irq_n !== 1 || status !== 8'h00) begin
            n_fail++;
            $display("FAIL R12: got lp=%b pp=%b irq_n=%b st=%h, exp 0 0 1 00",
                     lt_pend, px_pend, irq_n, status);
        end

        // R4: code 0 fires on an in-range result; R11 timing; R9 status bit 4
        lt_lo = 100; lt_hi = 1000; lt_en = 1; lt_pers = 0;
        lt_res(500, "R4 light code0 in-range");
        lt_clr = 1; step("R6 light clear");

        // R1: equality boundaries stay in range
        lt_pers = 1;
        lt_res(100, "R1 equal low");
        lt_res(1000, "R1 equal high");
        lt_res(99, "R1 just below");
        lt_clr = 1; step("R6 clear");
        lt_res(1001, "R1 just above");
        lt_clr = 1; step("R6 clear");

        // R5: in-range restarts the run (code 2 -> 2 results)
        lt_pers = 2;
        lt_res(50, "R5 first oor");
        step("R5 idle keeps run");
        lt_res(500, "R5 in-range restart");
        lt_res(50, "R5 oor after restart");
        lt_res(2000, "R5 second oor fires");
        lt_clr = 1; step("R6 clear");
        lt_res(500, "R5 in-range");

        // R2: light scale, code 4 -> 5, code 15 -> 60
        lt_pers = 4;
        for (int i = 0; i < 5; i++) lt_res(5, "R2 code4 run");
        lt_clr = 1; lt_valid = 1; lt_data = 500; step("R2 reset run");
        lt_pers = 15;
        for (int i = 0; i < 61; i++) lt_res(5, "R2 code15 run");
        lt_clr = 1; lt_valid = 1; lt_data = 500; step("R2 reset run");
        lt_pers = 3;
        for (int i = 0; i < 3; i++) lt_res(5, "R2 code3 run");
        lt_clr = 1; lt_valid = 1; lt_data = 500; step("R2 reset run");

        // R3: proximity linear scale
        px_lo = 10; px_hi = 200; px_en = 1; px_pers = 15;
        for (int i = 0; i < 15; i++) px_res(300, "R3 prox code15");
        px_clr = 1; px_valid = 1; px_data = 50; step("R3 reset run");
        px_pers = 7;
        for (int i = 0; i < 7; i++) px_res(3, "R3 prox code7");

        // R6: independent clears, both pending
        lt_pers = 0; lt_res(500, "R6 set light");
        lt_clr = 1; step("R6 clear light only");
        step("R6 prox still pending");
        px_clr = 1; step("R6 clear prox");

        // R7: clear coinciding with a firing result
        lt_clr = 1; lt_res(500, "R7 clear with fire");
        px_pers = 0; px_clr = 1; px_res(50, "R7 prox clear with fire");

        // R10: disable masks irq but flag stays
        lt_en = 0; step("R10 light masked");
        px_en = 0; step("R10 both masked");
        lt_en = 1; px_en = 1; step("R10 unmasked");
        lt_clr = 1; px_clr = 1; step("R6 clear both");

        // R8: firing while disabled sets nothing
        lt_en = 0; px_en = 0;
        lt_res(500, "R8 light disabled");
        px_res(50, "R8 prox disabled");
        lt_en = 1; px_en = 1; step("R8 enable after");

        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule